// File: doc/BRIEF.md
# Inset Field-Memory Write Scheduler

This block decides, once per input field, whether the inset picture of that field is stored into the field memory, and at which start address. A 4-bit period code selects one of three behaviours. The zero code gives live operation, with every field stored. The codes in the middle give strobed capture, whose period grows by four fields per code step. The all-ones code gives a still picture, with no further stores.

A mode bit turns on multi-strobe operation. Successive captures then rotate through up to six memory partitions, so that several stills are shown side by side. A clear request stores a flat background field and restarts the schedule. A background flag replaces the content of the scheduled stores with the flat level. All inputs are sampled on the field-start pulse, and the outputs hold for the whole field.

Top module: `inset_write_sched`

## Requirements
- R1: After reset, wr_en, fill_bg and wr_addr are all zero.
- R2: With strobe_code 0 and no clear request, every field start gives wr_en=1.
- R3: With strobe_code c in 1..14 held, a field is stored when the number of fields since the schedule restart is a multiple of 4*c+2. The restart field itself is stored.
- R4: With strobe_code 15 and no clear request, wr_en=0 on every field.
- R5: When strobe_code differs from the code seen on the previous field start, or on the first field start after reset, the schedule restarts. That field is stored unless the code is 15.
- R6: With multi_en=1, a field's address is base_addr + slot*STRIDE. The slot index starts at 0 on a restart and advances by one after each scheduled store. It returns to 0 after the last slot. The last slot is pic_code, and values 5, 6 and 7 all mean six slots (last slot 5). A slot beyond a reduced count reads as 0.
- R7: With multi_en=0, wr_addr equals base_addr, and the slot index returns to 0.
- R8: A clear_req sampled at a field start gives wr_en=1 and fill_bg=1 for that field, whatever the code is. It restarts the schedule and the slot index, as in R5.
- R9: bg_fill=1 gives fill_bg=1 on scheduled stores. On fields that are not stored it has no effect, and fill_bg=0 there.
- R10: wr_en, wr_addr and fill_bg change only at the clock edge that samples fld_start=1. Input changes between field starts leave them unchanged.
- R11: The address sum wraps modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fld_start | input | 1 | One-cycle pulse at the start of each input field |
| strobe_code | input | CODE_W | Capture period code: 0 live, 15 still, otherwise a store every 4*code+2 fields |
| multi_en | input | 1 | 1 rotates captures across picture slots |
| pic_code | input | PIC_W | Last slot index (0 = one picture, 5 = six pictures) |
| base_addr | input | AW | Base write start address |
| clear_req | input | 1 | Store a background field and restart the schedule |
| bg_fill | input | 1 | Scheduled stores carry background instead of picture |
| wr_en | output | 1 | The current field is stored |
| wr_addr | output | AW | Write start address for the current field |
| fill_bg | output | 1 | The current store is flat background |

## Verification
The bench builds the block with STRIDE=1500 and the default 13-bit address. With that stride, slots four and five added to a high base address pass 8191, so the address wrap can be reached alongside ordinary partition offsets. Directed runs hold the longest strobe period (58 fields) for two full cycles. They also switch codes in the middle of a period and shrink the slot count below the current slot. Random fields mix rare code changes, clear requests and mode toggles with input changes between field starts.

// File: rtl/inset_write_sched.sv
module inset_write_sched #(
  parameter int AW = 13,
  parameter int CODE_W = 4,
  parameter int PIC_W = 3,
  parameter int NSLOT_MAX = 6,
  parameter logic [AW-1:0] STRIDE = 13'd1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fld_start,
  input  logic [CODE_W-1:0] strobe_code,
  input  logic              multi_en,
  input  logic [PIC_W-1:0]  pic_code,
  input  logic [AW-1:0]     base_addr,
  input  logic              clear_req,
  input  logic              bg_fill,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic              fill_bg
);
  localparam int CNTW = CODE_W + 2;
  localparam logic [PIC_W-1:0] LAST_MAX = PIC_W'(NSLOT_MAX - 1);

  logic [CODE_W-1:0] code_q;
  logic              started;
  logic [CNTW-1:0]   cnt;
  logic [PIC_W-1:0]  slot;

  wire freeze  = &strobe_code;
  wire changed = !started || (strobe_code != code_q);
  wire restart = changed || clear_req;

  wire [CNTW-1:0] pos      = restart ? '0 : cnt;
  wire [CNTW-1:0] last_pos = (strobe_code == '0) ? '0 : {strobe_code, 2'b01};
  wire            hit      = !freeze && (pos == '0);

  wire [PIC_W-1:0] last_slot = (pic_code > LAST_MAX) ? LAST_MAX : pic_code;
  wire [PIC_W-1:0] cur_slot  = (restart || !multi_en || slot > last_slot) ? '0 : slot;
  wire [PIC_W-1:0] nxt_slot  = (hit && multi_en) ?
                               ((cur_slot == last_slot) ? '0 : cur_slot + 1'b1) : cur_slot;

  wire [AW-1:0] offs = AW'(cur_slot) * STRIDE;
  wire [AW-1:0] addr = base_addr + offs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      started <= 1'b0;
      cnt     <= '0;
      slot    <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      fill_bg <= 1'b0;
    end else if (fld_start) begin
      code_q  <= strobe_code;
      started <= 1'b1;
      cnt     <= (freeze || pos == last_pos) ? '0 : pos + 1'b1;
      slot    <= nxt_slot;
      wr_en   <= hit || clear_req;
      wr_addr <= addr;
      fill_bg <= clear_req || (hit && bg_fill);
    end
  end

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fld_start |=> $stable(wr_en) && $stable(wr_addr) && $stable(fill_bg)); // R10
  AST_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    fld_start && strobe_code == '0 |=> wr_en); // R2
  AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    fld_start && (&strobe_code) && !clear_req |=> !wr_en); // R4
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    fld_start && started && strobe_code != code_q |=> wr_en || $past(&strobe_code)); // R5
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    fld_start && clear_req |=> wr_en && fill_bg); // R8
  AST_FILL_ONLY_ON_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    fill_bg |-> wr_en); // R9
  AST_NORMAL_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    fld_start && !multi_en |=> wr_addr == $past(base_addr)); // R7
  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    slot <= LAST_MAX); // R6
endmodule

// File: tb/test_inset_write_sched.sv
`timescale 1ns/1ps
module test_inset_write_sched;
  localparam int AW = 13;
  localparam logic [AW-1:0] STRIDE = 13'd1500;

  logic clk = 0, rst_n = 0, fld_start = 0;
  logic [3:0] strobe_code = 0;
  logic multi_en = 0, clear_req = 0, bg_fill = 0;
  logic [2:0] pic_code = 0;
  logic [AW-1:0] base_addr = 0;
  logic wr_en, fill_bg;
  logic [AW-1:0] wr_addr;

  inset_write_sched #(.AW(AW), .STRIDE(STRIDE)) i_inset_write_sched (
    .clk(clk), .rst_n(rst_n), .fld_start(fld_start), .strobe_code(strobe_code),
    .multi_en(multi_en), .pic_code(pic_code), .base_addr(base_addr),
    .clear_req(clear_req), .bg_fill(bg_fill),
    .wr_en(wr_en), .wr_addr(wr_addr), .fill_bg(fill_bg));

  always #4 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;

  bit m_started = 0;
  int m_code = 0, m_k = 0, m_slot = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int period_of(input int c);
    return (c == 0) ? 1 : 4 * c + 2;
  endfunction

  task automatic field(input int code, input bit multi, input int pic, input int base,
                       input bit clr, input bit bg, input int gap, input string en_tag);
    bit restart, hit, wrapped;
    int n, cur, e_addr, raw;
    bit e_en, e_fill;
    logic se, sf;
    logic [AW-1:0] sa;
    @(negedge clk);
    strobe_code = 4'(code); multi_en = multi; pic_code = 3'(pic);
    base_addr = AW'(base); clear_req = clr; bg_fill = bg; fld_start = 1;
    restart = !m_started || code != m_code || clr;
    if (restart) m_k = 0;
    hit = (code != 15) && (m_k % period_of(code) == 0);
    n = (pic > 5) ? 6 : pic + 1;
    cur = (restart || !multi) ? 0 : ((m_slot >= n) ? 0 : m_slot);
    raw = base + cur * int'(STRIDE);
    wrapped = raw > 8191;
    e_addr = raw % 8192;
    e_en = hit || clr;
    e_fill = clr || (hit && bg);
    m_k++;
    m_slot = (hit && multi) ? (cur + 1) % n : cur;
    m_code = code; m_started = 1;
    @(negedge clk);
    fld_start = 0;
    if (en_tag != "") chk(en_tag, wr_en, e_en);
    else chk(clr ? "R8 wr_en" : code == 15 ? "R4 wr_en" : code == 0 ? "R2 wr_en" : "R3 wr_en",
             wr_en, e_en);
    chk(clr ? "R8 fill_bg" : "R9 fill_bg", fill_bg, e_fill);
    chk(!multi ? "R7 wr_addr" : wrapped ? "R11 wr_addr" : "R6 wr_addr", wr_addr, e_addr);
    se = wr_en; sf = fill_bg; sa = wr_addr;
    for (int g = 0; g < gap; g++) begin
      strobe_code = 4'($urandom); multi_en = 1'($urandom); pic_code = 3'($urandom);
      base_addr = AW'($urandom); clear_req = 1'($urandom); bg_fill = 1'($urandom);
      @(negedge clk);
    end
    if (gap > 0) chk("R10 hold", {se, sf, sa}, {wr_en, fill_bg, wr_addr});
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=<190000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    int code, base, pic;
    bit multi, bg;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk("R1 reset", {wr_en, fill_bg, wr_addr}, 0);
    rst_n = 1;
    for (int i = 0; i < 4; i++) field(0, 0, 0, 100, 0, 0, 1, "");
    for (int i = 0; i < 14; i++) field(1, 0, 0, 200, 0, 0, 0, "");
    field(2, 0, 0, 0, 0, 0, 0, "R5 first field of new code");
    field(2, 0, 0, 0, 0, 0, 0, "");
    field(3, 0, 0, 0, 0, 0, 0, "R5 mid-period change");
    for (int i = 0; i < 120; i++) field(14, 0, 0, 7, 0, 1, 0, "");
    for (int i = 0; i < 8; i++) field(15, 1, 2, 9, 0, 1, 1, "");
    field(15, 1, 2, 9, 1, 0, 1, "R8 clear on still");
    for (int i = 0; i < 16; i++) field(0, 1, 5, 7000, 0, 0, 0, "");
    for (int i = 0; i < 10; i++) field(0, 1, 7, 100, 0, 0, 0, "");
    field(0, 1, 5, 8000, 0, 0, 0, ""); field(0, 1, 5, 8000, 0, 0, 0, "");
    field(0, 1, 5, 8000, 0, 0, 0, ""); field(0, 1, 5, 8000, 0, 0, 0, "");
    field(0, 1, 1, 8000, 0, 0, 0, "");
    for (int i = 0; i < 20; i++) field(1, 1, 3, 50, 0, 0, 0, "");
    field(1, 0, 3, 50, 0, 0, 0, "");
    code = 0; multi = 0; pic = 2; base = 0; bg = 0;
    for (int i = 0; i < 2000; i++) begin
      if ($urandom_range(0, 99) < 4) code = $urandom_range(0, 15);
      if ($urandom_range(0, 99) < 3) multi = !multi;
      if ($urandom_range(0, 99) < 3) pic = $urandom_range(0, 7);
      if ($urandom_range(0, 99) < 5) base = $urandom_range(0, 8191);
      if ($urandom_range(0, 99) < 10) bg = !bg;
      field(code, multi, pic, base, $urandom_range(0, 99) < 3, bg, $urandom_range(0, 2), "");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule